// File: doc/BRIEF.md
# Majority-Capable Resistive Memory Array

This block is a behavioral model of a small resistive memory array and its command controller. It treats computation as memory access. A plain read senses one cell. An inverting read senses one cell and returns the complement. A majority read raises three adjacent word lines in one column, so the sense path returns the majority of the three stored bits. A write stores a 0 or a 1 into one cell. There is no arithmetic unit. Multi-level logic, for example a full adder, is built by reading a majority or inverted value and writing it back into rows that a later majority read picks up.

Each command takes one clock cycle. The block registers the sensed bit, the word-line pattern and the per-operation control levels (sense enable, output inversion, triple-row select, and the bit-line and source-line write drives), and it raises a one-cycle done pulse. One sense amplifier serves each group of eight columns. A vector majority command therefore evaluates every group at once, using the same lane inside each group. A majority whose base row leaves fewer than three rows below it is refused with an error pulse.

Top module: `majmem_array`

## Requirements
- R1: After reset, rd_bit, rd_vec, done, err, sa_en, out_inv, tri_sel, bl_set, sl_reset and wl_act are all 0, and every cell holds 0.
- R2: A command with cmd_op = 2'b00 (read) makes the following cycle show done=1, rd_bit equal to the cell at (cmd_row, cmd_col), sa_en=1, out_inv=0, tri_sel=0, and wl_act with only bit cmd_row set.
- R3: A command with cmd_op = 2'b01 (inverted read) behaves like a read, except that rd_bit is the complement of the cell and out_inv=1.
- R4: A command with cmd_op = 2'b10 and cmd_vec=0 (majority) returns rd_bit = ab+bc+ac, where a, b and c are the cells at rows cmd_row, cmd_row+1 and cmd_row+2 of column cmd_col. It shows sa_en=1, tri_sel=1, out_inv=0, and exactly those three bits set in wl_act.
- R5: A majority command with cmd_vec=1 sets rd_vec[g] to the majority over the same three rows at column g*8 + cmd_col[2:0], for every group g, and leaves rd_bit unchanged.
- R6: A command with cmd_op = 2'b11 (write) stores cmd_wdata into the cell at (cmd_row, cmd_col). In the following cycle it shows sa_en=0, a single-row wl_act, and bl_set=1, sl_reset=0 when writing 0, or bl_set=0, sl_reset=1 when writing 1. rd_bit and rd_vec stay unchanged.
- R7: A majority command with cmd_row greater than ROWS-3 (13 by default) gives done=1 and err=1 in the following cycle. wl_act and all control levels are 0, and rd_bit and rd_vec keep their values.
- R8: done is high in exactly the cycle after each accepted command. In a cycle after cmd_valid=0, done, wl_act and all control levels are 0.
- R9: A value written by one command is what the next command senses, so chained majority, inverted-read and write commands produce the sum and carry of a 1-bit full adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 inverted read, 10 majority, 11 write |
| cmd_vec | input | 1 | Majority evaluated in every sense group |
| cmd_row | input | 4 | Row, or base row for majority |
| cmd_col | input | 6 | Column; low 3 bits select the lane in vector mode |
| cmd_wdata | input | 1 | Bit to store on write |
| rd_bit | output | 1 | Registered sensed bit |
| rd_vec | output | 8 | Registered per-group majority results |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Majority base row out of range |
| sa_en | output | 1 | Sense amplifier enabled |
| out_inv | output | 1 | Inverted output selected |
| tri_sel | output | 1 | Triple-row activation |
| bl_set | output | 1 | Bit line driven to set level (write 0) |
| sl_reset | output | 1 | Source line driven to reset level (write 1) |
| wl_act | output | 16 | Active word lines |

## Verification
The assertions assume that cmd_op, cmd_row and cmd_vec hold known values whenever cmd_valid is high, and that no command arrives while rst_n is low. The stimulus meets this. Every input is set on the falling edge to a defined value, cmd_valid is held for one cycle per command, and the command fields keep defined values while idle. Out-of-range base rows are issued only as majority commands, which exercise the refusal path.

// File: rtl/majmem_array.sv
module majmem_array #(
  parameter int ROWS     = 16,
  parameter int COLS     = 64,
  parameter int SA_SHARE = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic                       cmd_vec,
  input  logic [$clog2(ROWS)-1:0]    cmd_row,
  input  logic [$clog2(COLS)-1:0]    cmd_col,
  input  logic                       cmd_wdata,
  output logic                       rd_bit,
  output logic [COLS/SA_SHARE-1:0]   rd_vec,
  output logic                       done,
  output logic                       err,
  output logic                       sa_en,
  output logic                       out_inv,
  output logic                       tri_sel,
  output logic                       bl_set,
  output logic                       sl_reset,
  output logic [ROWS-1:0]            wl_act
);
  localparam int RW        = $clog2(ROWS);
  localparam int LW        = $clog2(SA_SHARE);
  localparam int NGRP      = COLS / SA_SHARE;
  localparam int LAST_BASE = ROWS - 3;

  localparam logic [1:0] OP_READ = 2'b00;
  localparam logic [1:0] OP_NOT  = 2'b01;
  localparam logic [1:0] OP_MAJ  = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b11;

  logic [COLS-1:0] cells [ROWS];

  wire [RW-1:0]   row1 = cmd_row + RW'(1);
  wire [RW-1:0]   row2 = cmd_row + RW'(2);
  wire [COLS-1:0] ra   = cells[cmd_row];
  wire [COLS-1:0] rb   = cells[row1];
  wire [COLS-1:0] rc   = cells[row2];
  wire [COLS-1:0] maj_all = (ra & rb) | (rb & rc) | (ra & rc);
  wire [LW-1:0]   lane = cmd_col[LW-1:0];
  wire            row_ovf = int'(cmd_row) > LAST_BASE;

  wire [ROWS-1:0] one_row   = ROWS'(1) << cmd_row;
  wire [ROWS-1:0] three_row = one_row | (one_row << 1) | (one_row << 2);

  logic [NGRP-1:0] maj_vec;
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wire [SA_SHARE-1:0] grp = maj_all[g*SA_SHARE +: SA_SHARE];
    assign maj_vec[g] = grp[lane];
  end

  wire sensed = (cmd_op == OP_MAJ) ? maj_all[cmd_col] : ra[cmd_col];
  wire sa_out = (cmd_op == OP_NOT) ? ~sensed : sensed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      rd_bit   <= 1'b0;
      rd_vec   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      sa_en    <= 1'b0;
      out_inv  <= 1'b0;
      tri_sel  <= 1'b0;
      bl_set   <= 1'b0;
      sl_reset <= 1'b0;
      wl_act   <= '0;
    end else begin
      done     <= cmd_valid;
      err      <= 1'b0;
      sa_en    <= 1'b0;
      out_inv  <= 1'b0;
      tri_sel  <= 1'b0;
      bl_set   <= 1'b0;
      sl_reset <= 1'b0;
      wl_act   <= '0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_READ, OP_NOT: begin
            sa_en   <= 1'b1;
            out_inv <= (cmd_op == OP_NOT);
            wl_act  <= one_row;
            rd_bit  <= sa_out;
          end
          OP_MAJ: begin
            if (row_ovf) begin
              err <= 1'b1;
            end else begin
              sa_en   <= 1'b1;
              tri_sel <= 1'b1;
              wl_act  <= three_row;
              if (cmd_vec) rd_vec <= maj_vec;
              else         rd_bit <= sa_out;
            end
          end
          default: begin
            wl_act   <= one_row;
            bl_set   <= ~cmd_wdata;
            sl_reset <= cmd_wdata;
            cells[cmd_row][cmd_col] <= cmd_wdata;
          end
        endcase
      end
    end
  end

  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_set || sl_reset) |-> (!sa_en && !out_inv && !tri_sel && $onehot({bl_set, sl_reset})
                              && $countones(wl_act) == 1));

  assert_inv_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_inv |-> (sa_en && !tri_sel && $countones(wl_act) == 1));

  assert_three_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tri_sel |-> (sa_en && !out_inv && $countones(wl_act) == 3));

  assert_single_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tri_sel && !err) |-> $countones(wl_act) == 1);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && wl_act == '0 && !sa_en && $stable(rd_bit) && $stable(rd_vec)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (wl_act == '0 && !sa_en && !bl_set && !sl_reset && !err));

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
endmodule

// File: tb/tb_majmem_array.sv
module tb_majmem_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_vec = 1'b0;
  logic [3:0]  cmd_row = '0;
  logic [5:0]  cmd_col = '0;
  logic        cmd_wdata = 1'b0;
  logic        rd_bit, done, err, sa_en, out_inv, tri_sel, bl_set, sl_reset;
  logic [7:0]  rd_vec;
  logic [15:0] wl_act;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  majmem_array dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vec(cmd_vec), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .rd_bit(rd_bit), .rd_vec(rd_vec), .done(done), .err(err), .sa_en(sa_en),
    .out_inv(out_inv), .tri_sel(tri_sel), .bl_set(bl_set), .sl_reset(sl_reset),
    .wl_act(wl_act)
  );

  // {a, b, cin, sum, cout}
  localparam logic [4:0] FA_TAB [8] = '{
    5'b000_0_0, 5'b001_1_0, 5'b010_1_0, 5'b011_0_1,
    5'b100_1_0, 5'b101_0_1, 5'b110_0_1, 5'b111_1_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int row, input int col,
                     input logic wd, input logic vec);
    @(negedge clk);
    cmd_op = op; cmd_row = 4'(row); cmd_col = 6'(col); cmd_wdata = wd; cmd_vec = vec;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input int row, input int col, input logic wd);
    cmd(2'b11, row, col, wd, 1'b0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic cout, ncin, t, ncout, sum;
    logic [7:0] exp_vec;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_bit", rd_bit, 0);
    chk("R1 rd_vec", rd_vec, 0);
    chk("R1 done/err", {done, err}, 0);
    chk("R1 controls", {sa_en, out_inv, tri_sel, bl_set, sl_reset}, 0);
    chk("R1 wl_act", wl_act, 0);
    rst_n = 1'b1;
    cmd(2'b00, 7, 33, 0, 0);
    chk("R1 cell cleared", rd_bit, 0);

    // R6 write 1
    wr(5, 13, 1'b1);
    chk("R6 write1 drives", {bl_set, sl_reset, sa_en}, 3'b010);
    chk("R6 write wl", wl_act, 16'h0020);
    chk("R6 rd_bit unchanged", rd_bit, 0);
    // R8 idle cycle
    @(negedge clk);
    chk("R8 idle quiet", {done, sa_en, bl_set, sl_reset, err}, 0);
    chk("R8 idle wl", wl_act, 0);

    // R2 read
    cmd(2'b00, 5, 13, 0, 0);
    chk("R2 read value", rd_bit, 1);
    chk("R2 read ctl", {done, sa_en, out_inv, tri_sel}, 4'b1100);
    chk("R2 read wl", wl_act, 16'h0020);
    cmd(2'b00, 5, 12, 0, 0);
    chk("R2 neighbour col", rd_bit, 0);

    // R3 inverted read
    cmd(2'b01, 5, 13, 0, 0);
    chk("R3 not of 1", rd_bit, 0);
    chk("R3 inv ctl", {sa_en, out_inv, tri_sel}, 3'b110);
    cmd(2'b01, 4, 13, 0, 0);
    chk("R3 not of 0", rd_bit, 1);

    // R6 write 0, R9 visible next command
    wr(5, 13, 1'b0);
    chk("R6 write0 drives", {bl_set, sl_reset, sa_en}, 3'b100);
    chk("R6 rd_bit unchanged", rd_bit, 1);
    cmd(2'b00, 5, 13, 0, 0);
    chk("R9 write then read", rd_bit, 0);

    // R4 scalar majority
    wr(10, 40, 1); wr(11, 40, 0); wr(12, 40, 1);
    cmd(2'b10, 10, 40, 0, 0);
    chk("R4 maj 101", rd_bit, 1);
    chk("R4 maj wl", wl_act, 16'h1C00);
    chk("R4 maj ctl", {sa_en, tri_sel, out_inv}, 3'b110);
    wr(10, 40, 0);
    cmd(2'b10, 10, 40, 0, 0);
    chk("R4 maj 001", rd_bit, 0);

    // R4 last valid base row
    wr(13, 0, 1); wr(14, 0, 1); wr(15, 0, 0);
    cmd(2'b10, 13, 0, 0, 0);
    chk("R4 base row 13", rd_bit, 1);
    chk("R4 base row 13 wl", wl_act, 16'hE000);

    // R7 out of range
    cmd(2'b10, 14, 0, 0, 0);
    chk("R7 err row14", {done, err}, 2'b11);
    chk("R7 wl zero", wl_act, 0);
    chk("R7 controls zero", {sa_en, tri_sel}, 0);
    chk("R7 rd_bit held", rd_bit, 1);
    cmd(2'b10, 15, 0, 0, 1);
    chk("R7 err row15", err, 1);
    chk("R7 rd_vec held", rd_vec, 0);
    cmd(2'b00, 13, 0, 0, 0);
    chk("R7 err clears", err, 0);

    // R5 vector majority, lane 3, group g holds g%4 ones
    exp_vec = '0;
    for (int g = 0; g < 8; g++) begin
      int n = g % 4;
      wr(0, g*8 + 3, n >= 1);
      wr(1, g*8 + 3, n >= 2);
      wr(2, g*8 + 3, n >= 3);
      exp_vec[g] = (n >= 2);
    end
    cmd(2'b00, 0, 0, 0, 0);
    chk("R5 prelude read", rd_bit, 0);
    cmd(2'b10, 0, 11, 0, 1);
    chk("R5 vector lane3", rd_vec, exp_vec);
    chk("R5 rd_bit unchanged", rd_bit, 0);
    cmd(2'b10, 0, 2, 0, 1);
    chk("R5 vector lane2", rd_vec, 0);

    // R9 full adder by chaining, column 60
    for (int i = 0; i < 8; i++) begin
      logic a, b, c;
      {a, b, c} = FA_TAB[i][4:2];
      wr(0, 60, a); wr(1, 60, b); wr(2, 60, c);
      cmd(2'b10, 0, 60, 0, 0); cout = rd_bit;
      chk("R4 adder carry", cout, FA_TAB[i][0]);
      cmd(2'b01, 2, 60, 0, 0); ncin = rd_bit;
      chk("R3 adder not cin", ncin, !c);
      wr(3, 60, a); wr(4, 60, b); wr(5, 60, ncin);
      cmd(2'b10, 3, 60, 0, 0); t = rd_bit;
      wr(9, 60, cout);
      cmd(2'b01, 9, 60, 0, 0); ncout = rd_bit;
      wr(6, 60, ncout); wr(7, 60, c); wr(8, 60, t);
      cmd(2'b10, 6, 60, 0, 0); sum = rd_bit;
      chk("R9 adder sum", sum, FA_TAB[i][1]);
    end

    summary();
  end
endmodule